// File: doc/BRIEF.md
# Translation Table Base Selector

This block keeps the control word that steers the first stage of address translation and turns it, together with a faulting virtual address, into the start condition of a table walk. When the TLB misses, the block picks one of two table base registers, forms the aligned table base address, decides whether a walk may start or a translation fault must be raised instead, and says which base register supplies the address space identifier. In the long format it also hands the walker the shareability and cacheability hints of the chosen base.

The control word has two layouts, picked by its top bit: a 32-bit short-descriptor layout and a 40-bit long-descriptor layout. Each layout has its own set of writable bits. There are two copies of the word, one secure and one non-secure. A register port with a copy select reads and writes them. A separate select input chooses the copy that steers translation. An external lock input can freeze the secure copy against writes.

Register writes take effect at the next clock edge. All walk outputs are combinational from the stored word of the active copy and the current address and base inputs.

Top module: `tbsel_top`

## Requirements
- R1: After reset both copies of the control word read as 0, so translation starts in short layout with split field 0.
- R2: A written word whose bit 31 is 0 is stored in short layout. Only bits 31, 5, 4 and 2:0 are kept; every other bit reads back 0.
- R3: A written word whose bit 31 is 1 is stored in long layout. Only bits 31, 29:22, 18:16, 13:7 and 2:0 are kept (mask 0xBFC73F87); bits 30, 21:19, 15:14 and 6:3 read back 0.
- R4: A register write goes to the secure copy when regSecSel is 1 and to the non-secure copy otherwise. A secure write made while secDisable is 1 leaves the secure copy unchanged. walkSec=1 makes the secure copy steer translation; walkSec=0 makes the non-secure copy steer it.
- R5: In short layout with split field n = bits 2:0, baseSel is 1 exactly when the top n bits of va are not all zero. With n = 0, baseSel is always 0.
- R6: In short layout, walkBase is base0 with bits 13-n down to 0 cleared when baseSel is 0, and base1 with bits 13:0 cleared when baseSel is 1.
- R7: In long layout with size fields s0 = bits 2:0 and s1 = bits 18:16, the rules are checked in this order:
  - an address below 2^(32-s0) selects base 0;
  - otherwise an address at or above 2^32 - 2^(32-s1) selects base 1;
  - any other address falls in a hole, which raises a fault and starts no walk.
- R8: In long layout, walkBase is the chosen base register with bits 2:0 cleared.
- R9: The walk-disable bits are bit 4 (base 0) and bit 5 (base 1) in short layout, and bit 7 (base 0) and bit 23 (base 1) in long layout. A miss routed to a disabled base raises xlatFault and leaves walkGo low.
- R10: With missValid low, walkGo and xlatFault are both 0. With missValid high, exactly one of them is 1.
- R11: In long layout, asidSel equals bit 22. In short layout, asidSel is 0.
- R12: In long layout, the walk hints come from the chosen base's field group:
  - base 0: walkShare = bits 13:12, walkOuter = bits 11:10, walkInner = bits 9:8;
  - base 1: walkShare = bits 29:28, walkOuter = bits 27:26, walkInner = bits 25:24.

  In short layout all three are 0.
- R13: A write is visible on regRdData in the cycle after its clock edge. regRdData shows the copy named by regSecSel, and the walk outputs follow va and the base inputs with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| secDisable | input | 1 | Locks the secure copy against writes |
| regWrEn | input | 1 | Register write strobe |
| regSecSel | input | 1 | Copy select for register read and write (1 = secure) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data of the selected copy |
| walkSec | input | 1 | Copy that steers translation (1 = secure) |
| missValid | input | 1 | A TLB miss needs a walk decision |
| va | input | 32 | Faulting virtual address |
| base0 | input | 32 | Table base register 0 |
| base1 | input | 32 | Table base register 1 |
| baseSel | output | 1 | Chosen base register index |
| walkBase | output | 32 | Aligned table base for the walk |
| walkGo | output | 1 | Walk may start |
| xlatFault | output | 1 | Translation fault instead of a walk |
| asidSel | output | 1 | Base register that supplies the ASID |
| walkShare | output | 2 | Shareability hint for walk accesses |
| walkOuter | output | 2 | Outer cacheability hint for walk accesses |
| walkInner | output | 2 | Inner cacheability hint for walk accesses |
| longFmt | output | 1 | Active copy is in long layout |

## Verification
A wrong stored bit shows on regRdData in the cycle after the write. A register bit that should have been cleared, or a lost lock on the secure copy, shows the same way, one cycle after the offending write. A corrupt split or size field does not show at once. It shows only when va crosses the boundary it moves: baseSel changes, or a walk is replaced by a hole fault, in the same cycle the address is presented. The bench therefore sweeps every split and size value against addresses just either side of each region edge.

// File: rtl/tbsel_pkg.sv
package tbsel_pkg;

  localparam int CTL_W        = 32;
  localparam int FMT_BIT      = 31;
  localparam int SHORT_DIS0   = 4;
  localparam int LONG_DIS0    = 7;
  localparam int ASID_BIT     = 22;
  localparam int SIZE1_LO     = 16;
  localparam int FIELD_STRIDE = 16;
  localparam int SH_LO        = 12;
  localparam int OUT_LO       = 10;
  localparam int IN_LO        = 8;

  localparam logic [CTL_W-1:0] SHORT_KEEP = 32'h8000_0037;
  localparam logic [CTL_W-1:0] LONG_KEEP  = 32'hBFC7_3F87;

  typedef struct packed {
    logic wrSec;
    logic wrNs;
    logic rdSec;
    logic useSec;
  } ctlStrobe_t;

  typedef struct packed {
    logic [1:0] share;
    logic [1:0] outer;
    logic [1:0] inner;
  } walkAttr_t;

  function automatic logic [CTL_W-1:0] keepMask(input logic isLong);
    return isLong ? LONG_KEEP : SHORT_KEEP;
  endfunction

endpackage

// File: rtl/tbsel_ctrl.sv
module tbsel_ctrl
  import tbsel_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       regSecSel,
  input  logic       secDisable,
  input  logic       walkSec,
  output ctlStrobe_t stb
);

  logic secLocked;

  always_comb begin
    secLocked  = secDisable;
    stb.wrSec  = regWrEn && regSecSel && !secLocked;
    stb.wrNs   = regWrEn && !regSecSel;
    stb.rdSec  = regSecSel;
    stb.useSec = walkSec;
  end

  // R4
  one_copy_written_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrSec, stb.wrNs}));

  // R4
  ns_write_reaches_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regSecSel) |-> !stb.wrSec);

endmodule

// File: rtl/tbsel_regs.sv
module tbsel_regs
  import tbsel_pkg::*;
#(
  parameter int W = CTL_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctlStrobe_t   stb,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] rdData,
  output logic [W-1:0] activeCtl
);

  logic [W-1:0] secQ;
  logic [W-1:0] nsQ;
  logic [W-1:0] wrClean;

  assign wrClean = wrData & keepMask(wrData[FMT_BIT]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secQ <= '0;
      nsQ  <= '0;
    end else begin
      if (stb.wrSec) secQ <= wrClean;
      if (stb.wrNs)  nsQ  <= wrClean;
    end
  end

  assign rdData    = stb.rdSec  ? secQ : nsQ;
  assign activeCtl = stb.useSec ? secQ : nsQ;

  // R2 R3
  reserved_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((secQ & ~keepMask(secQ[FMT_BIT])) == '0) && ((nsQ & ~keepMask(nsQ[FMT_BIT])) == '0));

  // R4
  sec_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrSec |=> $stable(secQ));

  // R13
  ns_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrNs |=> $stable(nsQ));

endmodule

// File: rtl/tbsel_walk.sv
module tbsel_walk
  import tbsel_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int SHORT_ALIGN = 14,
  parameter int LONG_ALIGN  = 3,
  parameter int FIELD_W     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTL_W-1:0]  ctl,
  input  logic              missValid,
  input  logic [VA_W-1:0]   va,
  input  logic [VA_W-1:0]   base0,
  input  logic [VA_W-1:0]   base1,
  output logic              baseSel,
  output logic [VA_W-1:0]   walkBase,
  output logic              walkGo,
  output logic              xlatFault,
  output logic              asidSel,
  output walkAttr_t         attr,
  output logic              longFmt
);

  localparam logic [VA_W-1:0] ONES     = '1;
  localparam logic [VA_W-1:0] LONG_CUT = ONES << LONG_ALIGN;
  localparam logic [VA_W-1:0] HI_CUT   = ONES << SHORT_ALIGN;

  logic [FIELD_W-1:0] splitN;
  logic [FIELD_W-1:0] size0;
  logic [FIELD_W-1:0] size1;
  logic               shortSel;
  logic               inLow;
  logic               inHigh;
  logic               longSel;
  logic               hole;
  logic [1:0]         disBit;
  walkAttr_t          attrOf [2];
  logic [VA_W-1:0]    shortBase0;
  logic [VA_W-1:0]    shortBase1;
  logic               walkOk;

  assign longFmt = ctl[FMT_BIT];
  assign splitN  = ctl[FIELD_W-1:0];
  assign size0   = ctl[FIELD_W-1:0];
  assign size1   = ctl[SIZE1_LO +: FIELD_W];

  // short layout: upper split bits decide the base
  assign shortSel   = |(va & ~(ONES >> splitN));
  assign shortBase0 = base0 & (ONES << (SHORT_ALIGN - int'(splitN)));
  assign shortBase1 = base1 & HI_CUT;

  // long layout: low region, high region, or a hole between
  assign inLow   = ~|(va & ~(ONES >> size0));
  assign inHigh  = &(va | (ONES >> size1));
  assign longSel = !inLow;
  assign hole    = !inLow && !inHigh;

  for (genvar i = 0; i < 2; i++) begin : g_base
    assign disBit[i]       = longFmt ? ctl[LONG_DIS0 + FIELD_STRIDE*i] : ctl[SHORT_DIS0 + i];
    assign attrOf[i].share = ctl[SH_LO  + FIELD_STRIDE*i +: 2];
    assign attrOf[i].outer = ctl[OUT_LO + FIELD_STRIDE*i +: 2];
    assign attrOf[i].inner = ctl[IN_LO  + FIELD_STRIDE*i +: 2];
  end

  always_comb begin
    baseSel = longFmt ? longSel : shortSel;
    if (longFmt) begin
      walkBase = (baseSel ? base1 : base0) & LONG_CUT;
      attr     = baseSel ? attrOf[1] : attrOf[0];
      asidSel  = ctl[ASID_BIT];
    end else begin
      walkBase = baseSel ? shortBase1 : shortBase0;
      attr     = '0;
      asidSel  = 1'b0;
    end
    walkOk    = !(longFmt && hole) && !disBit[baseSel];
    walkGo    = missValid && walkOk;
    xlatFault = missValid && !walkOk;
  end

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !missValid |-> (!walkGo && !xlatFault));

  // R9
  disabled_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    walkGo |-> !(ctl[FMT_BIT] ? ctl[LONG_DIS0 + FIELD_STRIDE*int'(baseSel)]
                              : ctl[SHORT_DIS0 + int'(baseSel)]));

  // R5
  short_zero_split_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl[FMT_BIT] && ctl[FIELD_W-1:0] == '0) |-> !baseSel);

  // R11
  asid_short_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl[FMT_BIT] |-> !asidSel);

  // R12
  short_attr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl[FMT_BIT] |-> (attr == '0));

  // R8
  long_base_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl[FMT_BIT] |-> (walkBase[LONG_ALIGN-1:0] == '0));

endmodule

// File: rtl/tbsel_top.sv
module tbsel_top
  import tbsel_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             secDisable,
  input  logic             regWrEn,
  input  logic             regSecSel,
  input  logic [CTL_W-1:0] regWrData,
  output logic [CTL_W-1:0] regRdData,
  input  logic             walkSec,
  input  logic             missValid,
  input  logic [VA_W-1:0]  va,
  input  logic [VA_W-1:0]  base0,
  input  logic [VA_W-1:0]  base1,
  output logic             baseSel,
  output logic [VA_W-1:0]  walkBase,
  output logic             walkGo,
  output logic             xlatFault,
  output logic             asidSel,
  output logic [1:0]       walkShare,
  output logic [1:0]       walkOuter,
  output logic [1:0]       walkInner,
  output logic             longFmt
);

  ctlStrobe_t       stb;
  logic [CTL_W-1:0] activeCtl;
  walkAttr_t        attr;

  tbsel_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regSecSel (regSecSel),
    .secDisable(secDisable),
    .walkSec   (walkSec),
    .stb       (stb)
  );

  tbsel_regs #(.W(CTL_W)) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (regWrData),
    .rdData   (regRdData),
    .activeCtl(activeCtl)
  );

  tbsel_walk #(.VA_W(VA_W)) u_walk (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (activeCtl),
    .missValid(missValid),
    .va       (va),
    .base0    (base0),
    .base1    (base1),
    .baseSel  (baseSel),
    .walkBase (walkBase),
    .walkGo   (walkGo),
    .xlatFault(xlatFault),
    .asidSel  (asidSel),
    .attr     (attr),
    .longFmt  (longFmt)
  );

  assign walkShare = attr.share;
  assign walkOuter = attr.outer;
  assign walkInner = attr.inner;

  // R4
  sec_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSecSel && secDisable) |=> $stable(u_regs.secQ));

endmodule

// File: tb/tb_tbsel_top.sv
module tb_tbsel_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        secDisable = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regSecSel = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        walkSec = 1'b0;
  logic        missValid = 1'b0;
  logic [31:0] va = '0;
  logic [31:0] base0 = '0;
  logic [31:0] base1 = '0;
  logic        baseSel;
  logic [31:0] walkBase;
  logic        walkGo;
  logic        xlatFault;
  logic        asidSel;
  logic [1:0]  walkShare;
  logic [1:0]  walkOuter;
  logic [1:0]  walkInner;
  logic        longFmt;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  tbsel_top dut (
    .clk(clk), .rstN(rstN), .secDisable(secDisable), .regWrEn(regWrEn),
    .regSecSel(regSecSel), .regWrData(regWrData), .regRdData(regRdData),
    .walkSec(walkSec), .missValid(missValid), .va(va), .base0(base0), .base1(base1),
    .baseSel(baseSel), .walkBase(walkBase), .walkGo(walkGo), .xlatFault(xlatFault),
    .asidSel(asidSel), .walkShare(walkShare), .walkOuter(walkOuter),
    .walkInner(walkInner), .longFmt(longFmt)
  );

  task automatic check(input string req, input longint unsigned got, input longint unsigned exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] cleanWord(input logic [31:0] d);
    return d[31] ? (d & 32'hBFC7_3F87) : (d & 32'h8000_0037);
  endfunction

  task automatic writeCopy(input logic sec, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSecSel = sec; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readCheck(input string req, input logic sec, input logic [31:0] exp);
    regSecSel = sec;
    #1;
    check(req, regRdData, exp);
  endtask

  // expected walk outcome computed arithmetically from the stored word
  task automatic walkCheck(input logic [31:0] ctl, input logic [31:0] addr);
    longint unsigned a, lowLim, hiStart;
    int n, s0, s1;
    logic sel, hole, dis, expAsid;
    logic [31:0] expBase;
    logic [1:0] eSh, eOut, eIn;
    string tagSel, tagBase;
    a = addr;
    va = addr; missValid = 1'b1;
    if (!ctl[31]) begin
      n = int'(ctl[2:0]);
      sel = ((a >> (32 - n)) != 0);
      hole = 1'b0;
      dis = sel ? ctl[5] : ctl[4];
      if (sel) expBase = base1 - (base1 % 32'd16384);
      else     expBase = base0 - (base0 % (32'd1 << (14 - n)));
      expAsid = 1'b0; eSh = 2'b00; eOut = 2'b00; eIn = 2'b00;
      tagSel = "R5 short select"; tagBase = "R6 short base";
    end else begin
      s0 = int'(ctl[2:0]); s1 = int'(ctl[18:16]);
      lowLim  = 64'd1 << (32 - s0);
      hiStart = (64'd1 << 32) - (64'd1 << (32 - s1));
      sel  = !(a < lowLim);
      hole = sel && !(a >= hiStart);
      dis  = sel ? ctl[23] : ctl[7];
      expBase = (sel ? base1 : base0);
      expBase = expBase - (expBase % 32'd8);
      expAsid = ctl[22];
      eSh  = 2'((ctl >> (sel ? 28 : 12)) & 3);
      eOut = 2'((ctl >> (sel ? 26 : 10)) & 3);
      eIn  = 2'((ctl >> (sel ? 24 : 8))  & 3);
      tagSel = "R7 long select"; tagBase = "R8 long base";
    end
    #1;
    check(tagSel, baseSel, sel);
    check(tagBase, walkBase, expBase);
    check("R9 walk start", walkGo, !(hole || dis));
    check("R9 fault", xlatFault, hole || dis);
    check("R11 asid source", asidSel, expAsid);
    check("R12 walk hints", {walkShare, walkOuter, walkInner}, {eSh, eOut, eIn});
    check("R13 layout flag", longFmt, ctl[31]);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [31:0] vaList [6];
    base0 = 32'hDEAD_BEEF; base1 = 32'h1357_9BDF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readCheck("R1 ns reset", 1'b0, 32'h0);
    readCheck("R1 sec reset", 1'b1, 32'h0);
    regSecSel = 1'b0;
    walkCheck(32'h0, 32'hFFFF_FFFF);

    // R10 no miss, no outcome
    missValid = 1'b0; va = 32'h8000_0000;
    #1;
    check("R10 idle go", walkGo, 1'b0);
    check("R10 idle fault", xlatFault, 1'b0);

    // R2 / R3 write masking, R13 readback next cycle
    writeCopy(1'b0, 32'h7FFF_FFFF);
    readCheck("R2 short keep", 1'b0, 32'h0000_0037);
    writeCopy(1'b1, 32'hFFFF_FFFF);
    readCheck("R3 long keep", 1'b1, 32'hBFC7_3F87);
    readCheck("R13 copy select", 1'b0, 32'h0000_0037);

    // R4 secure lock
    secDisable = 1'b1;
    writeCopy(1'b1, 32'h0000_0001);
    readCheck("R4 locked secure", 1'b1, 32'hBFC7_3F87);
    writeCopy(1'b0, 32'h0000_0012);
    readCheck("R4 ns unaffected by lock", 1'b0, 32'h0000_0012);
    secDisable = 1'b0;

    // R4 secure copy steers: sizes 7/7 with both disables set, always fault
    walkSec = 1'b1;
    walkCheck(32'hBFC7_3F87, 32'h0000_0100);
    walkCheck(32'hBFC7_3F87, 32'hFFFF_FF00);
    walkCheck(32'hBFC7_3F87, 32'h4000_0000);
    walkSec = 1'b0;

    // R5 R6 R9 short sweep over every split value
    for (int n = 0; n < 8; n++) begin
      w = cleanWord(32'(n) | (32'(n % 4) << 4) | 32'h7FFF_FFC8);
      writeCopy(1'b0, w);
      readCheck("R2 short sweep readback", 1'b0, w);
      vaList[0] = 32'h0;
      vaList[1] = (n == 0) ? 32'h1234_5678 : 32'((64'd1 << (32 - n)));
      vaList[2] = 32'((64'd1 << (32 - n)) - 1);
      vaList[3] = 32'hFFFF_FFFF;
      vaList[4] = 32'h8000_0000;
      vaList[5] = 32'h0ABC_DEF0;
      for (int k = 0; k < 6; k++) begin
        base0 = 32'hA5A5_3C3C ^ 32'(k * 32'h0101_0707);
        base1 = 32'h5A5A_C3C3 ^ 32'(n * 32'h0011_2233);
        walkCheck(w, vaList[k]);
      end
    end

    // R7 R8 R9 R11 R12 long sweep over every pair of size fields
    for (int s0 = 0; s0 < 8; s0++) begin
      for (int s1 = 0; s1 < 8; s1++) begin
        w = 32'h8000_0000 | 32'(s0) | (32'(s1) << 16)
          | (32'((s0 + s1) & 3) << 12) | (32'(s0 & 3) << 10) | (32'(s1 & 3) << 8)
          | (32'(s1 & 3) << 28) | (32'((s0 ^ s1) & 3) << 26) | (32'(s0 & 3) << 24)
          | (32'(s0 & 1) << 22) | ((((s0 + s1) % 5) == 1) ? 32'h80 : 32'h0)
          | ((((s0 + s1) % 5) == 3) ? 32'h0080_0000 : 32'h0)
          | 32'h4038_C078;
        writeCopy(1'b0, w);
        w = cleanWord(w);
        readCheck("R3 long sweep readback", 1'b0, w);
        vaList[0] = 32'h0;
        vaList[1] = 32'((64'd1 << (32 - s0)) - 1);
        vaList[2] = 32'((64'd1 << (32 - s0)) & 64'hFFFF_FFFF);
        vaList[3] = 32'((64'd1 << 32) - (64'd1 << (32 - s1)));
        vaList[4] = 32'((64'd1 << 32) - (64'd1 << (32 - s1)) - 1);
        vaList[5] = 32'hFFFF_FFFF;
        for (int k = 0; k < 6; k++) begin
          base0 = 32'h3141_5927 + 32'(k * 33);
          base1 = 32'h2718_2818 + 32'(s0 * 7 + s1);
          walkCheck(w, vaList[k]);
        end
      end
    end

    missValid = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule